// File: doc/BRIEF.md
# Two-wire bus error monitor

This block observes the clock and data lines of a two-wire serial bus and finds START or STOP conditions placed where a frame forbids them. It follows each frame bit by bit: after a START it counts the completed bits of the address or data byte and the acknowledge bit that closes the nine-bit frame. A START or STOP seen while a byte or an acknowledge bit is still in progress is a bus error. The block then raises an interrupt flag and reports an error status code to the host.

While no event is pending, the status code shows a fixed "nothing to report" value. To leave the error state, the host requests a stop and clears the flag in one control write. The block then returns to the idle, non-addressed slave state and clears the stop request by itself. It lets go of both lines and never drives a STOP condition onto the bus. While the error is pending, it can hold the clock line low, chosen by a parameter, so that the bus stalls until software has seen the error.

Top module: `twi_buserr_mon`

## Requirements
- R1: While the interrupt flag is clear, the status output reads 0xF8. This includes the state after reset and all idle bus time.
- R2: While a bus error is pending (interrupt flag set), the status output reads 0x00.
- R3: A START is SDA falling while SCL stays high, and a STOP is SDA rising while SCL stays high. Both lines pass a two-flop synchronizer, so a flag caused by a line change driven just after clock edge N becomes visible just after edge N+3.
- R4: After a START, `frame_act` is 1 and `frame_pos` counts completed bits, where a completed bit is an SCL high phase followed by SCL falling. The count runs 0 to 8 and wraps to 0 when the ninth (acknowledge) bit completes.
- R5: A START or STOP while `frame_act` is 1 and `frame_pos` is 1 to 8 is a bus error and sets the interrupt flag. Positions 1 to 8 are inside a byte or in the acknowledge bit.
- R6: A START or STOP at `frame_pos` 0 is legal and leaves the flag clear. A repeated START restarts the frame at position 0, and a STOP drops `frame_act` to 0.
- R7: While a bus error is pending, all bus activity is ignored: `frame_act` stays 0 and `frame_pos` stays 0.
- R8: A control write with stop=1 and flag_clr=1 while an error is pending recovers. After that clock edge the flag is 0, the status is 0xF8, `stop_req` is 0 and `ack_en` takes the written value.
- R9: Any other control write leaves the flag unchanged and loads `stop_req` and `ack_en` from the written values.
- R10: `sda_oe` is always 0, so the block never drives a STOP. `scl_oe` is 1 exactly while an error is pending (HOLD_SCL=1) and is 0 after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_stop | input | 1 | Written value of the stop-request bit |
| ctl_flag_clr | input | 1 | Write one to clear the interrupt flag |
| ctl_ack_en | input | 1 | Written value of the acknowledge-enable bit |
| status | output | 8 | Status code (0xF8 idle, 0x00 bus error) |
| irq_flag | output | 1 | Interrupt flag |
| stop_req | output | 1 | Stop-request control bit |
| ack_en | output | 1 | Acknowledge-enable control bit |
| frame_act | output | 1 | A frame is open (START seen, no STOP yet) |
| frame_pos | output | 4 | Completed bits in the current frame, 0 to 8 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A line change reaches the flag, the status and `scl_oe` three clock edges after the bench drives it: two synchronizer stages and then the error register. A control write takes effect on the first edge. The bench drives all inputs on falling clock edges. Its reference model keeps the line history in queues, so it uses the same two-sample delay when it decides where events fall. Every output is compared with the model on every falling edge. The directed checks on the R3 latency sample two and three falling edges after the drive, so both the cycle before and the cycle after the flag changes are pinned.

// File: rtl/twi_mon_pkg.sv
package twi_mon_pkg;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
   } bus_evt_t;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det
   import twi_mon_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic scl_steady_hi;
   assign scl_steady_hi = scl_s & scl_q;

   always_comb begin
      evt          = '0;
      evt.start    = scl_steady_hi &  sda_q & ~sda_s;
      evt.stop     = scl_steady_hi & ~sda_q &  sda_s;
      evt.scl_rise =  scl_s & ~scl_q;
      evt.scl_fall = ~scl_s &  scl_q;
   end
endmodule

// File: rtl/twi_pos_track.sv
module twi_pos_track
   import twi_mon_pkg::*;
#(
   parameter int FRAME_BITS = 9,
   parameter int POS_W      = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_evt_t         evt,
   input  logic             clear,
   output logic             frame_act,
   output logic [POS_W-1:0] frame_pos
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   logic seen_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_act <= 1'b0;
         frame_pos <= '0;
         seen_hi   <= 1'b0;
      end else if (clear) begin
         frame_act <= 1'b0;
         frame_pos <= '0;
         seen_hi   <= 1'b0;
      end else if (evt.start) begin
         frame_act <= 1'b1;
         frame_pos <= '0;
         seen_hi   <= 1'b0;
      end else if (evt.stop) begin
         frame_act <= 1'b0;
         frame_pos <= '0;
         seen_hi   <= 1'b0;
      end else if (frame_act) begin
         if (evt.scl_rise) begin
            seen_hi <= 1'b1;
         end else if (evt.scl_fall && seen_hi) begin
            seen_hi   <= 1'b0;
            frame_pos <= (frame_pos == LAST_POS) ? '0 : frame_pos + POS_W'(1);
         end
      end
   end
endmodule

// File: rtl/twi_err_ctl.sv
module twi_err_ctl #(
   parameter logic [7:0] IDLE_CODE = 8'hF8,
   parameter logic [7:0] ERR_CODE  = 8'h00,
   parameter bit         HOLD_SCL  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       illegal,
   input  logic       ctl_wr,
   input  logic       ctl_stop,
   input  logic       ctl_flag_clr,
   input  logic       ctl_ack_en,
   output logic       irq_flag,
   output logic [7:0] status,
   output logic       stop_req,
   output logic       ack_en,
   output logic       scl_oe,
   output logic       sda_oe
);
   logic recover, flag_n;

   assign recover = irq_flag & ctl_wr & ctl_stop & ctl_flag_clr;

   always_comb begin
      flag_n = irq_flag;
      if (illegal && !irq_flag) flag_n = 1'b1;
      else if (recover)         flag_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag <= 1'b0;
         status   <= IDLE_CODE;
         stop_req <= 1'b0;
         ack_en   <= 1'b0;
      end else begin
         irq_flag <= flag_n;
         status   <= flag_n ? ERR_CODE : IDLE_CODE;
         if (recover)     stop_req <= 1'b0;
         else if (ctl_wr) stop_req <= ctl_stop;
         if (ctl_wr)      ack_en   <= ctl_ack_en;
      end
   end

   generate
      if (HOLD_SCL) begin : g_hold
         assign scl_oe = irq_flag;
      end else begin : g_nohold
         assign scl_oe = 1'b0;
      end
   endgenerate

   assign sda_oe = 1'b0;
endmodule

// File: rtl/twi_buserr_mon.sv
module twi_buserr_mon
   import twi_mon_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FRAME_BITS  = 9,
   parameter logic [7:0] IDLE_CODE   = 8'hF8,
   parameter logic [7:0] ERR_CODE    = 8'h00,
   parameter bit         HOLD_SCL    = 1'b1,
   localparam int        POS_W       = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             ctl_wr,
   input  logic             ctl_stop,
   input  logic             ctl_flag_clr,
   input  logic             ctl_ack_en,
   output logic [7:0]       status,
   output logic             irq_flag,
   output logic             stop_req,
   output logic             ack_en,
   output logic             frame_act,
   output logic [POS_W-1:0] frame_pos,
   output logic             scl_oe,
   output logic             sda_oe
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("FRAME_BITS must be at least 2");
      end
      if (IDLE_CODE == ERR_CODE) begin : g_bad_codes
         $error("IDLE_CODE and ERR_CODE must differ");
      end
   endgenerate

   logic     scl_s, sda_s;
   bus_evt_t evt;
   logic     illegal;

   twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );

   twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   twi_cond_det u_det (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
   );

   assign illegal = (evt.start | evt.stop) & frame_act & (frame_pos != '0);

   twi_pos_track #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clear(irq_flag | illegal),
      .frame_act(frame_act), .frame_pos(frame_pos)
   );

   twi_err_ctl #(.IDLE_CODE(IDLE_CODE), .ERR_CODE(ERR_CODE), .HOLD_SCL(HOLD_SCL)) u_err (
      .clk(clk), .rst_n(rst_n), .illegal(illegal),
      .ctl_wr(ctl_wr), .ctl_stop(ctl_stop), .ctl_flag_clr(ctl_flag_clr),
      .ctl_ack_en(ctl_ack_en),
      .irq_flag(irq_flag), .status(status), .stop_req(stop_req), .ack_en(ack_en),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );
endmodule

// File: rtl/twi_buserr_mon_chk.sv
module twi_buserr_mon_chk #(
   parameter int         POS_W      = 4,
   parameter int         FRAME_BITS = 9,
   parameter logic [7:0] IDLE_CODE  = 8'hF8,
   parameter logic [7:0] ERR_CODE   = 8'h00
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_flag,
   input logic [7:0]       status,
   input logic             stop_req,
   input logic             frame_act,
   input logic [POS_W-1:0] frame_pos,
   input logic             ctl_wr,
   input logic             ctl_stop,
   input logic             ctl_flag_clr,
   input logic             scl_oe,
   input logic             sda_oe
);
   // R1
   status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_flag |-> status == IDLE_CODE);

   // R2
   status_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag |-> status == ERR_CODE);

   // R4
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pos <= POS_W'(FRAME_BITS - 1));

   // R5
   err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> ($past(frame_act) && $past(frame_pos) != '0));

   // R7
   idle_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag |=> !frame_act);

   // R8
   recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && ctl_wr && ctl_stop && ctl_flag_clr) |=> (!irq_flag && !stop_req));

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !(ctl_wr && ctl_stop && ctl_flag_clr)) |=> irq_flag);

   // R10
   sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe == 1'b0);

   // R10
   scl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag) |-> !scl_oe);
endmodule

bind twi_buserr_mon twi_buserr_mon_chk #(
   .POS_W(POS_W), .FRAME_BITS(FRAME_BITS), .IDLE_CODE(IDLE_CODE), .ERR_CODE(ERR_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .status(status),
   .stop_req(stop_req), .frame_act(frame_act), .frame_pos(frame_pos),
   .ctl_wr(ctl_wr), .ctl_stop(ctl_stop), .ctl_flag_clr(ctl_flag_clr),
   .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/twi_buserr_mon_test.sv
`timescale 1ns/1ps
module twi_buserr_mon_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_i = 1'b1, sda_i = 1'b1;
   logic       ctl_wr = 1'b0, ctl_stop = 1'b0, ctl_flag_clr = 1'b0, ctl_ack_en = 1'b0;
   logic [7:0] status;
   logic       irq_flag, stop_req, ack_en, frame_act, scl_oe, sda_oe;
   logic [3:0] frame_pos;

   twi_buserr_mon uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .ctl_wr(ctl_wr), .ctl_stop(ctl_stop), .ctl_flag_clr(ctl_flag_clr),
      .ctl_ack_en(ctl_ack_en), .status(status), .irq_flag(irq_flag),
      .stop_req(stop_req), .ack_en(ack_en), .frame_act(frame_act),
      .frame_pos(frame_pos), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   localparam int PH = 6;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit sh[$], dh[$];
   bit m_flag, m_act, m_seen, m_stop, m_ack;
   int m_pos;

   always @(posedge clk) begin
      if (!rst_n) begin
         sh = '{1'b1, 1'b1, 1'b1};
         dh = '{1'b1, 1'b1, 1'b1};
         m_flag = 0; m_act = 0; m_seen = 0; m_stop = 0; m_ack = 0; m_pos = 0;
      end else begin
         bit st, sp, ri, fa, bad, rec;
         st  = sh[1] && sh[2] && dh[2] && !dh[1];
         sp  = sh[1] && sh[2] && !dh[2] && dh[1];
         ri  = sh[1] && !sh[2];
         fa  = !sh[1] && sh[2];
         bad = (st || sp) && m_act && m_pos != 0 && !m_flag;
         rec = m_flag && ctl_wr && ctl_stop && ctl_flag_clr;
         if (m_flag || bad) begin
            m_act = 0; m_pos = 0; m_seen = 0;
         end else if (st) begin
            m_act = 1; m_pos = 0; m_seen = 0;
         end else if (sp) begin
            m_act = 0; m_pos = 0; m_seen = 0;
         end else if (m_act) begin
            if (ri) m_seen = 1;
            else if (fa && m_seen) begin
               m_seen = 0;
               m_pos = (m_pos + 1) % 9;
            end
         end
         if (bad) m_flag = 1;
         else if (rec) m_flag = 0;
         if (rec) m_stop = 0;
         else if (ctl_wr) m_stop = ctl_stop;
         if (ctl_wr) m_ack = ctl_ack_en;
         sh.push_front(scl_i); void'(sh.pop_back());
         dh.push_front(sda_i); void'(dh.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(status == (m_flag ? 8'h00 : 8'hF8), "R1/R2 status vs model", status, m_flag ? 8'h00 : 8'hF8);
         chk(irq_flag == m_flag, "R5 flag vs model", irq_flag, m_flag);
         chk(frame_act == m_act, "R4 frame_act vs model", frame_act, m_act);
         chk(int'(frame_pos) == m_pos, "R4 frame_pos vs model", frame_pos, m_pos);
         chk(stop_req == m_stop, "R9 stop_req vs model", stop_req, m_stop);
         chk(ack_en == m_ack, "R9 ack_en vs model", ack_en, m_ack);
         chk(scl_oe == m_flag, "R10 scl_oe vs model", scl_oe, m_flag);
         chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drive(input bit c, input bit d);
      @(negedge clk);
      scl_i = c; sda_i = d;
   endtask

   task automatic ph(input bit c, input bit d);
      drive(c, d);
      repeat (PH - 1) @(negedge clk);
   endtask

   task automatic do_start();  ph(1, 1); ph(1, 0); ph(0, 0); endtask
   task automatic do_rstart(); ph(0, 1); ph(1, 1); ph(1, 0); ph(0, 0); endtask
   task automatic do_stop();   ph(0, 0); ph(1, 0); ph(1, 1); endtask
   task automatic do_bit(input bit b); ph(0, b); ph(1, b); ph(0, b); endtask
   task automatic do_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) do_bit(v[i]);
   endtask

   task automatic wr_ctl(input bit s, input bit c, input bit a);
      @(negedge clk);
      ctl_wr = 1; ctl_stop = s; ctl_flag_clr = c; ctl_ack_en = a;
      @(negedge clk);
      ctl_wr = 0; ctl_stop = 0; ctl_flag_clr = 0; ctl_ack_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(status == 8'hF8, "R1 status after reset", status, 8'hF8);
      chk(irq_flag == 0, "R1 flag after reset", irq_flag, 0);

      // R4 / R6 legal traffic with a repeated START
      do_start();
      chk(frame_act == 1, "R4 frame open after START", frame_act, 1);
      do_bit(1); do_bit(0); do_bit(1);
      chk(frame_pos == 3, "R4 position after three bits", frame_pos, 3);
      do_bit(0); do_bit(0); do_bit(1); do_bit(0); do_bit(1);
      chk(frame_pos == 8, "R4 position after eight bits", frame_pos, 8);
      do_bit(0);
      chk(frame_pos == 0, "R4 wrap after acknowledge", frame_pos, 0);
      do_rstart();
      chk(irq_flag == 0 && frame_act == 1, "R6 repeated START legal", irq_flag, 0);
      do_byte(8'h3C); do_bit(0);
      do_stop();
      chk(frame_act == 0 && irq_flag == 0, "R6 STOP closes frame", frame_act, 0);

      // R9 write outside error
      wr_ctl(1, 1, 1);
      chk(irq_flag == 0 && stop_req == 1 && ack_en == 1, "R9 write without error", irq_flag, 0);
      wr_ctl(0, 0, 1);

      // R5 / R3 illegal START inside a byte
      do_start();
      do_bit(1); do_bit(1); do_bit(0);
      ph(0, 1); ph(1, 1);
      drive(1, 0);
      repeat (2) @(negedge clk);
      chk(irq_flag == 0, "R3 flag not yet set two edges after", irq_flag, 0);
      @(negedge clk);
      chk(irq_flag == 1, "R3 R5 flag set three edges after", irq_flag, 1);
      chk(status == 8'h00, "R2 error status", status, 8'h00);
      chk(scl_oe == 1, "R10 SCL held during error", scl_oe, 1);
      repeat (PH) @(negedge clk);

      // R7 activity ignored during error
      ph(0, 0); ph(1, 1); ph(1, 0); ph(0, 0);
      do_bit(1);
      chk(frame_act == 0 && frame_pos == 0, "R7 tracker idle in error", frame_act, 0);

      // R9 partial writes keep the flag
      wr_ctl(0, 1, 1);
      chk(irq_flag == 1 && stop_req == 0, "R9 clear without stop keeps flag", irq_flag, 1);
      wr_ctl(1, 0, 1);
      chk(irq_flag == 1 && stop_req == 1, "R9 stop without clear keeps flag", stop_req, 1);

      // R8 recovery
      wr_ctl(1, 1, 0);
      chk(irq_flag == 0, "R8 flag cleared", irq_flag, 0);
      chk(status == 8'hF8, "R8 status idle", status, 8'hF8);
      chk(stop_req == 0, "R8 stop request self-cleared", stop_req, 0);
      chk(ack_en == 0, "R8 ack enable as written", ack_en, 0);
      chk(scl_oe == 0 && sda_oe == 0, "R10 lines released", scl_oe, 0);

      // R5 STOP in the acknowledge bit
      ph(1, 1);
      do_start();
      do_byte(8'hC3);
      ph(0, 0); ph(1, 0); ph(1, 1);
      chk(irq_flag == 1 && status == 8'h00, "R5 STOP during acknowledge", irq_flag, 1);
      wr_ctl(1, 1, 1);
      chk(irq_flag == 0 && ack_en == 1, "R8 second recovery", irq_flag, 0);
      repeat (10) @(negedge clk);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule